// File: doc/BRIEF.md
# MLC Page Read Sequencer with Paired-Page Recovery Retry

This block is a host-side controller that reads one page from a NAND flash device that has an on-chip data buffer and a 16-bit register file. After a start pulse it writes the address registers and issues the page load command. It then polls the interrupt register, selects the buffer and sets up the ECC configuration. Next it reads the four ECC status words and the controller status word. Each status word is captured into an output register as it arrives.

If the controller status reports an uncorrectable load error, the whole sequence runs once more with the recovery read command. This command reconstructs a lower page whose paired upper-page program was cut short by power loss. The retry uses the address values captured at start. A failed retry ends the run with a fatal flag. A missing interrupt ends it with a timeout flag. Moving data out of the buffer and computing ECC are left to other logic.

Top module: `nand_recovery_seq`

## Requirements
- R1: After reset, and whenever no run is active, `busy`, `done` and `reg_req` are low. `done` stays low while `busy` is high.
- R2: A run begins with three writes in this order: `blk_addr` to 16'hF100, `page_addr` to 16'hF107, then the command to 16'hF220. The command is 16'h0000 on the first pass and 16'h0005 on the recovery pass.
- R3: After the command, the block reads 16'hF241 repeatedly. It leaves the polling step only after a read with bit 15 set; all other bits of that read are ignored.
- R4: After the interrupt the block writes, in order: `buf_sel` to 16'hF101, 16'h0000 to 16'hF241, 16'h0800 to 16'hF200, and `ecc_mode` to 16'hF221. The write to 16'hF241 is omitted when `auto_irq` was high at start.
- R5: The block then reads 16'hFF00, 16'hFF01, 16'hFF02 and 16'hFF03 in that order. Lane i of `ecc_stat` (bits 16i+15 down to 16i) holds the data of the read from 16'hFF00+i.
- R6: The block finally reads 16'hF240 and stores the value in `ctrl_stat`. If bit 10 is clear, the run ends with `done` high and `err_fatal` low.
- R7: If bit 10 is set after the first pass, the full sequence of R2 to R6 runs again with command 16'h0005. It uses the address, buffer and configuration values captured at start, even if the inputs changed since then. `recovered` goes high when this retry begins.
- R8: If bit 10 is set after the recovery pass, the run ends with `done` and `err_fatal` high and no third pass is made.
- R9: The block counts the polling reads with bit 15 clear. When that count reaches `poll_limit` (a limit of 0 acts as 1), the run ends at once with `done` and `timed_out` high, and no further register transaction is made.
- R10: A transaction completes in a cycle where `reg_req` and `reg_ack` are both high. Until then `reg_addr`, `reg_we` and `reg_wdata` stay stable.
- R11: A `start` pulse while `busy` is high has no effect on the running sequence. A `start` pulse while idle clears all status outputs and captures the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a page read when idle |
| blk_addr | input | 16 | Device/block address word |
| page_addr | input | 16 | Page/sector address word |
| buf_sel | input | 16 | Buffer select word |
| ecc_mode | input | 16 | System configuration (ECC) word |
| auto_irq | input | 1 | Device clears its interrupt itself; skip the clear write |
| poll_limit | input | TO_W | Interrupt polling limit, in reads |
| reg_req | output | 1 | Register transaction request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data, valid with `reg_ack` |
| reg_ack | input | 1 | Transaction complete |
| busy | output | 1 | A run is active |
| done | output | 1 | Last run has ended; held until next start |
| err_fatal | output | 1 | Uncorrectable error persisted after recovery |
| timed_out | output | 1 | Interrupt not seen within the limit |
| recovered | output | 1 | The recovery pass was entered |
| ecc_stat | output | 64 | Four captured ECC status words |
| ctrl_stat | output | 16 | Captured controller status word |

## Verification
The bench drives runs with a variable acknowledge latency. Polling reads carry garbage in their low bits, so a design that tests the wrong interrupt bit stops polling too early or never stops. Runs where the error bit is set once, set twice or never set catch a design that skips the retry, sends the wrong command code or retries without end. A run with `auto_irq` catches a design that does not drop the clear write, and input changes during a run catch a retry that re-reads live inputs instead of the captured values. Timeouts in each pass, and a limit of zero, catch an off-by-one in the poll counter and any traffic after an abort.

// File: rtl/nand_recovery_seq.sv
module nand_recovery_seq #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [15:0]     blk_addr,
  input  logic [15:0]     page_addr,
  input  logic [15:0]     buf_sel,
  input  logic [15:0]     ecc_mode,
  input  logic            auto_irq,
  input  logic [TO_W-1:0] poll_limit,
  output logic            reg_req,
  output logic            reg_we,
  output logic [15:0]     reg_addr,
  output logic [15:0]     reg_wdata,
  input  logic [15:0]     reg_rdata,
  input  logic            reg_ack,
  output logic            busy,
  output logic            done,
  output logic            err_fatal,
  output logic            timed_out,
  output logic            recovered,
  output logic [63:0]     ecc_stat,
  output logic [15:0]     ctrl_stat
);

  typedef enum logic [3:0] {
    S_BLK, S_PAGE, S_CMD, S_POLL, S_BUF, S_CLR, S_BSA, S_CFG,
    S_E0, S_E1, S_E2, S_E3, S_STAT
  } step_t;

  localparam logic [15:0] CMD_LOAD = 16'h0000;
  localparam logic [15:0] CMD_RCVR = 16'h0005;
  localparam int          IRQ_BIT  = 15;
  localparam int          UNC_BIT  = 10;

  step_t            step;
  logic             pass;
  logic [15:0]      blk_q, page_q, buf_q, cfg_q;
  logic             auto_q;
  logic [TO_W-1:0]  lim_q, zcnt;
  logic             limit_hit;

  assign reg_req   = busy;
  assign limit_hit = ({1'b0, zcnt} + 1'b1) >= {1'b0, lim_q};

  always_comb begin
    reg_we    = 1'b1;
    reg_addr  = 16'h0000;
    reg_wdata = 16'h0000;
    case (step)
      S_BLK:   begin reg_addr = 16'hF100; reg_wdata = blk_q; end
      S_PAGE:  begin reg_addr = 16'hF107; reg_wdata = page_q; end
      S_CMD:   begin reg_addr = 16'hF220; reg_wdata = pass ? CMD_RCVR : CMD_LOAD; end
      S_POLL:  begin reg_addr = 16'hF241; reg_we = 1'b0; end
      S_BUF:   begin reg_addr = 16'hF101; reg_wdata = buf_q; end
      S_CLR:   begin reg_addr = 16'hF241; end
      S_BSA:   begin reg_addr = 16'hF200; reg_wdata = 16'h0800; end
      S_CFG:   begin reg_addr = 16'hF221; reg_wdata = cfg_q; end
      S_E0, S_E1, S_E2, S_E3:
               begin reg_addr = {14'h3FC0, step[1:0]}; reg_we = 1'b0; end
      S_STAT:  begin reg_addr = 16'hF240; reg_we = 1'b0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      step      <= S_BLK;
      pass      <= 1'b0;
      blk_q     <= '0;
      page_q    <= '0;
      buf_q     <= '0;
      cfg_q     <= '0;
      auto_q    <= 1'b0;
      lim_q     <= '0;
      zcnt      <= '0;
      done      <= 1'b0;
      err_fatal <= 1'b0;
      timed_out <= 1'b0;
      recovered <= 1'b0;
      ecc_stat  <= '0;
      ctrl_stat <= '0;
    end else if (!busy) begin
      if (start) begin
        busy      <= 1'b1;
        step      <= S_BLK;
        pass      <= 1'b0;
        blk_q     <= blk_addr;
        page_q    <= page_addr;
        buf_q     <= buf_sel;
        cfg_q     <= ecc_mode;
        auto_q    <= auto_irq;
        lim_q     <= poll_limit;
        zcnt      <= '0;
        done      <= 1'b0;
        err_fatal <= 1'b0;
        timed_out <= 1'b0;
        recovered <= 1'b0;
        ecc_stat  <= '0;
        ctrl_stat <= '0;
      end
    end else if (reg_ack) begin
      case (step)
        S_POLL: begin
          if (reg_rdata[IRQ_BIT]) begin
            step <= S_BUF;
            zcnt <= '0;
          end else if (limit_hit) begin
            busy      <= 1'b0;
            done      <= 1'b1;
            timed_out <= 1'b1;
          end else begin
            zcnt <= zcnt + 1'b1;
          end
        end
        S_BUF: step <= auto_q ? S_BSA : S_CLR;
        S_E0, S_E1, S_E2, S_E3: begin
          ecc_stat[16*step[1:0] +: 16] <= reg_rdata;
          step <= step_t'(step + 4'd1);
        end
        S_STAT: begin
          ctrl_stat <= reg_rdata;
          if (reg_rdata[UNC_BIT] && !pass) begin
            pass      <= 1'b1;
            recovered <= 1'b1;
            step      <= S_BLK;
          end else begin
            busy      <= 1'b0;
            done      <= 1'b1;
            err_fatal <= reg_rdata[UNC_BIT];
          end
        end
        default: step <= step_t'(step + 4'd1);
      endcase
    end
  end

endmodule

// File: rtl/nand_recovery_seq_chk.sv
module nand_recovery_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_req,
  input logic        reg_ack,
  input logic        reg_we,
  input logic [15:0] reg_addr,
  input logic [15:0] reg_wdata,
  input logic        busy,
  input logic        done,
  input logic        err_fatal,
  input logic        timed_out,
  input logic        recovered
);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !reg_req);

  p_done_not_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_cmd_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_addr == 16'hF220 |-> reg_we && (reg_wdata == 16'h0000 || reg_wdata == 16'h0005));

  p_irq_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_we && reg_addr == 16'hF241 |-> reg_wdata == 16'h0000);

  p_fatal_after_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_fatal |-> done && recovered && !timed_out);

  p_timeout_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> done && !err_fatal);

  p_recover_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_addr == 16'hF220 && reg_wdata == 16'h0005 |-> recovered);

endmodule

bind nand_recovery_seq nand_recovery_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_ack(reg_ack),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .busy(busy), .done(done), .err_fatal(err_fatal),
  .timed_out(timed_out), .recovered(recovered)
);

// File: tb/test_nand_recovery_seq.sv
module test_nand_recovery_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TO_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] blk_addr = '0, page_addr = '0, buf_sel = '0, ecc_mode = '0;
  logic auto_irq = 1'b0;
  logic [TO_W-1:0] poll_limit = '0;
  logic reg_req, reg_we;
  logic [15:0] reg_addr, reg_wdata;
  logic [15:0] reg_rdata = '0;
  logic reg_ack = 1'b0;
  logic busy, done, err_fatal, timed_out, recovered;
  logic [63:0] ecc_stat;
  logic [15:0] ctrl_stat;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_recovery_seq #(.TO_W(TO_W)) i_nand_recovery_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_addr(blk_addr),
    .page_addr(page_addr), .buf_sel(buf_sel), .ecc_mode(ecc_mode),
    .auto_irq(auto_irq), .poll_limit(poll_limit), .reg_req(reg_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ack(reg_ack), .busy(busy), .done(done),
    .err_fatal(err_fatal), .timed_out(timed_out), .recovered(recovered),
    .ecc_stat(ecc_stat), .ctrl_stat(ctrl_stat)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  logic [32:0] exp_q[$];
  int iw[2];
  logic [15:0] st[2];
  int rsp_pass = 0;
  int poll_n = 0;
  int txn_n = 0;
  int wait_cnt = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ecc_val(int p, int i);
    return 16'hEC00 | 16'(p << 4) | 16'(i);
  endfunction

  function automatic string tag_of(logic [32:0] e);
    if (e[32:16] == {1'b0, 16'hF241}) return "R3";
    if (e[31:18] == 14'h3FC0) return "R5";
    if (e[31:16] == 16'hF240) return "R6";
    if (e[31:16] == 16'hF100 || e[31:16] == 16'hF107 || e[31:16] == 16'hF220)
      return (rsp_pass == 1) ? "R7" : "R2";
    return "R4";
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Device responder and per-clock comparison against the expected transaction queue
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy || !reg_req, "R1", "request while idle", 64'(reg_req), 64'd0);
      chk(!(busy && done), "R1", "done while busy", 64'(done), 64'd0);
    end
    if (reg_ack) begin
      reg_ack = 1'b0;
      txn_n++;
      wait_cnt = 0;
    end else if (rst_n && reg_req) begin
      if (wait_cnt >= (txn_n * 5 + 1) % 3) begin
        if (exp_q.size() == 0) begin
          chk(0, "R9", "unexpected transaction", {31'd0, reg_we, reg_addr, reg_wdata}, 64'd0);
        end else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_of(e);
          chk(reg_we == e[32] && reg_addr == e[31:16], t, "transaction kind/address",
              {47'd0, reg_we, reg_addr}, {47'd0, e[32:16]});
          if (e[32])
            chk(reg_wdata == e[15:0], t, "write data", 64'(reg_wdata), 64'(e[15:0]));
        end
        reg_rdata = 16'h0000;
        if (reg_we && reg_addr == 16'hF220) begin
          rsp_pass = (reg_wdata == 16'h0005) ? 1 : 0;
          poll_n = 0;
        end else if (!reg_we && reg_addr == 16'hF241) begin
          reg_rdata = (poll_n < iw[rsp_pass]) ? 16'h7FFF : 16'h8123;
          poll_n++;
        end else if (!reg_we && reg_addr[15:2] == 14'h3FC0) begin
          reg_rdata = ecc_val(rsp_pass, int'(reg_addr[1:0]));
        end else if (!reg_we && reg_addr == 16'hF240) begin
          reg_rdata = st[rsp_pass];
        end
        reg_ack = 1'b1;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic push(bit we, logic [15:0] a, logic [15:0] d);
    exp_q.push_back({we, a, d});
  endtask

  task automatic build_pass(logic [15:0] cmd, int w, int lim, bit aut,
                            logic [15:0] b, logic [15:0] p, logic [15:0] s, logic [15:0] c,
                            output bit aborted);
    int l;
    l = (lim == 0) ? 1 : lim;
    aborted = 0;
    push(1, 16'hF100, b);
    push(1, 16'hF107, p);
    push(1, 16'hF220, cmd);
    if (w >= l) begin
      for (int k = 0; k < l; k++) push(0, 16'hF241, 0);
      aborted = 1;
      return;
    end
    for (int k = 0; k <= w; k++) push(0, 16'hF241, 0);
    push(1, 16'hF101, s);
    if (!aut) push(1, 16'hF241, 16'h0000);
    push(1, 16'hF200, 16'h0800);
    push(1, 16'hF221, c);
    for (int k = 0; k < 4; k++) push(0, 16'hFF00 + 16'(k), 0);
    push(0, 16'hF240, 0);
  endtask

  task automatic run_case(string name, int w0, int w1, logic [15:0] s0, logic [15:0] s1,
                          bit aut, int lim, logic [15:0] seed);
    bit ab, e_to, e_fat, e_rec;
    int lastp, n;
    logic [63:0] e_ecc;
    logic [15:0] e_ctrl;
    iw[0] = w0; iw[1] = w1; st[0] = s0; st[1] = s1;
    exp_q.delete();
    e_to = 0; e_fat = 0; e_rec = 0; lastp = 0; e_ctrl = s0;
    build_pass(16'h0000, w0, lim, aut, seed, seed ^ 16'h0101, seed ^ 16'h0202, seed ^ 16'h0303, ab);
    if (ab) begin
      e_to = 1; e_ctrl = 16'h0000;
    end else if (s0[10]) begin
      e_rec = 1; lastp = 1; e_ctrl = s1;
      build_pass(16'h0005, w1, lim, aut, seed, seed ^ 16'h0101, seed ^ 16'h0202, seed ^ 16'h0303, ab);
      if (ab) e_to = 1;
      else e_fat = s1[10];
    end
    e_ecc = 0;
    for (int k = 0; k < 4; k++) e_ecc[16*k +: 16] = ecc_val(lastp, k);
    @(negedge clk);
    blk_addr = seed; page_addr = seed ^ 16'h0101; buf_sel = seed ^ 16'h0202;
    ecc_mode = seed ^ 16'h0303; auto_irq = aut; poll_limit = TO_W'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R7/R11: captured inputs must be used; inputs now change and start pulses mid-run
    blk_addr = ~seed; page_addr = 16'hDEAD; buf_sel = 16'hBEEF; ecc_mode = 16'h5A5A;
    auto_irq = ~aut; poll_limit = TO_W'(lim + 7);
    @(negedge clk);
    @(negedge clk);
    if (busy) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R6", {name, " done"}, 64'(done), 64'd1);
    chk(exp_q.size() == 0, "R2", {name, " transactions left"}, 64'(exp_q.size()), 64'd0);
    chk(timed_out == e_to, "R9", {name, " timed_out"}, 64'(timed_out), 64'(e_to));
    chk(err_fatal == e_fat, "R8", {name, " err_fatal"}, 64'(err_fatal), 64'(e_fat));
    chk(recovered == e_rec, "R7", {name, " recovered"}, 64'(recovered), 64'(e_rec));
    if (!e_to) begin
      chk(ecc_stat == e_ecc, "R5", {name, " ecc_stat"}, ecc_stat, e_ecc);
      chk(ctrl_stat == e_ctrl, "R6", {name, " ctrl_stat"}, 64'(ctrl_stat), 64'(e_ctrl));
    end
    repeat (4) @(negedge clk);
    chk(!reg_req && done, "R9", {name, " quiet after end"}, 64'({reg_req, done}), 64'b01);
  endtask

  initial begin
    iw[0] = 0; iw[1] = 0; st[0] = 0; st[1] = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !reg_req, "R1", "reset state", 64'({busy, done, reg_req}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !reg_req, "R1", "idle after reset", 64'({busy, done, reg_req}), 64'd0);
    run_case("clean", 2, 0, 16'h0000, 16'h0000, 0, 10, 16'h1234);
    run_case("clean_other_bits", 0, 0, 16'hFBFF, 16'h0000, 0, 3, 16'h4321);
    run_case("recover_ok_auto", 1, 3, 16'h0400, 16'h0000, 1, 8, 16'hA0B0);
    run_case("recover_fail", 0, 1, 16'h0400, 16'h0400, 0, 5, 16'h0F0F);
    run_case("timeout_first", 5, 0, 16'h0000, 16'h0000, 0, 3, 16'h5555);
    run_case("timeout_zero_limit", 1, 0, 16'h0000, 16'h0000, 1, 0, 16'h7777);
    run_case("limit_edge_ok", 2, 0, 16'h0000, 16'h0000, 0, 3, 16'h2468);
    run_case("timeout_retry", 0, 9, 16'h0400, 16'h0000, 0, 4, 16'h1357);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule